// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter

This block provides two timer/counter channels. Each channel is made of a low byte and a high byte. A shared configuration register gives each channel a 2-bit operating mode, a source select and a gating enable. A shared control register holds one run bit and one overflow flag for each channel. A channel counts either a machine-cycle tick input or falling edges on its own external count pin. A channel can also be gated by its own external level pin, which makes pulse-width measurement possible. The overflow flags are driven straight to output pins, so surrounding logic can use them as interrupt requests.

Four modes are available. Mode 0 is a 13-bit counter built from the whole high byte and the five least significant bits of the low byte. Mode 1 is a full 16-bit counter. Mode 2 is an 8-bit counter in the low byte that reloads from the high byte when it overflows. Mode 3 behaves differently on each channel. On channel 1 it freezes the count. On channel 0 it splits the channel into two 8-bit counters:
- The low byte keeps channel 0's controls.
- The high byte counts machine ticks, is started by channel 1's run bit and sets channel 1's flag.

Software accesses the registers through a simple single-cycle register bus. Writes take effect on the clock edge. Reads are combinational.

Top module: `dual_tmr_ctr`

## Requirements
- R1: After reset, every register reads 0 and both flag outputs are 0. Both channels are therefore stopped, in mode 0, counting ticks.
- R2: A channel advances on a count event only while its run bit is 1 and either its gate enable is 0 or its gate pin is 1. Clearing the run bit freezes the count. Setting the run bit again continues from the held value and does not clear it.
- R3: In mode 1 (mode field 01), {high,low} counts as 16 bits. A step from 0xFFFF to 0x0000 sets the channel's flag.
- R4: In mode 0 (mode field 00), the count is {high byte, low[4:0]}. A step from all ones wraps to zero and sets the flag. Bits low[7:5] keep the value they had.
- R5: In mode 2 (mode field 10), only the low byte counts. A count event at low = 0xFF loads the high byte into the low byte and sets the flag. The high byte is not changed.
- R6: While channel 1 is in mode 3, its count bytes hold their values whatever its run bit is.
- R7: While channel 0 is in mode 3, its low byte is an 8-bit counter with channel 0's run bit, gate, source select and flag. Its high byte is an 8-bit counter that counts ticks whenever channel 1's run bit is 1. A step of the high byte from 0xFF to 0x00 sets channel 1's flag.
- R8: With the source select bit set (configuration bit 2 for channel 0, bit 6 for channel 1), each 1-to-0 transition of the count pin advances the channel by one. The pin first passes through a two-flop synchronizer. The tick input has no effect in this setting.
- R9: Writing a 0 to a flag bit of the control register clears it. An overflow in the same cycle as that write leaves the flag set. Control register layout: bit0 run 0, bit1 flag 0, bit2 run 1, bit3 flag 1.
- R10: While channel 0 is in mode 3, channel 1 in modes 0 to 2 still counts under its own run and gate, but its overflows do not set channel 1's flag.
- R11: A bus write to a count byte in the same cycle as a count event stores the written value, and that cycle's increment is lost.
- R12: Register addresses: 0 configuration, 1 control, 2 channel 0 low, 3 channel 0 high, 4 channel 1 low, 5 channel 1 high. Configuration layout: bits [1:0] channel 0 mode, bit2 channel 0 source select, bit3 channel 0 gate enable, bits [7:4] the same four fields for channel 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle count enable, one clock wide per machine cycle |
| cnt_pin | input | 2 | External count inputs, one per channel, asynchronous |
| gate_pin | input | 2 | External gate levels, one per channel |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ovf_flag | output | 2 | Overflow flags, bit i for channel i |

## Verification
The bench loads preset counts and runs a known number of ticks in each mode.

Mode tests:
- Start values just below the wrap point separate the 13-bit, 16-bit and reload arithmetic.
- Values far from the wrap point show that no flag is set early.
- The split-mode runs show which run bit and which flag each byte of channel 0 uses.
- A channel 1 run in mode 3 separates freezing from counting.

Control, source and gating tests:
- Toggling the gate pin, the run bit and the count pin shows that each of them qualifies counting.
- Tick pulses during counter operation show that the wrong source is ignored.
- Same-cycle collisions of a bus write with an increment, and of a flag clear with an overflow, show which side wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      MD_13     = 2'd0,
      MD_16     = 2'd1,
      MD_RELOAD = 2'd2,
      MD_SPLIT  = 2'd3
   } tmr_mode_e;

   typedef struct packed {
      logic      gate_en;
      logic      src_pin;
      tmr_mode_e mode;
   } chan_cfg_t;

   localparam int CFG_BITS = $bits(chan_cfg_t);

   localparam logic [2:0] A_CFG  = 3'd0;
   localparam logic [2:0] A_CTRL = 3'd1;
   localparam logic [2:0] A_LO0  = 3'd2;
   localparam logic [2:0] A_HI0  = 3'd3;
   localparam logic [2:0] A_LO1  = 3'd4;
   localparam logic [2:0] A_HI1  = 3'd5;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);
   initial begin
      assert (STAGES >= 2) else $fatal(1, "tmr_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], pin};
   end

   // a 1-to-0 step seen between the last synchronizer stage and its history flop
   assign fall = chain_q[STAGES] & ~chain_q[STAGES-1];

   // R8: one falling transition yields exactly one event
   p_single_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int PRE_W    = 5,
   parameter bit SPLIT_OK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tmr_mode_e         mode,
   input  logic              inc_main,
   input  logic              inc_hi,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] lo,
   output logic [BYTE_W-1:0] hi,
   output logic              ovf_main,
   output logic              ovf_hi
);
   localparam int W_SHORT = BYTE_W + PRE_W;
   localparam int W_FULL  = 2 * BYTE_W;

   initial begin
      assert (PRE_W > 0 && PRE_W < BYTE_W) else $fatal(1, "tmr_chan: PRE_W must lie in 1..BYTE_W-1");
   end

   logic              split;
   logic [BYTE_W-1:0] lo_n, hi_n;
   logic [W_SHORT-1:0] cur_short, nxt_short;
   logic [W_FULL-1:0]  nxt_full;
   logic              blk_main;

   generate
      if (SPLIT_OK) begin : g_split
         assign split = (mode == MD_SPLIT);
      end else begin : g_nosplit
         assign split = 1'b0;
      end
   endgenerate

   assign cur_short = {hi, lo[PRE_W-1:0]};
   assign nxt_short = cur_short + 1'b1;
   assign nxt_full  = {hi, lo} + 1'b1;
   assign blk_main  = split ? wr_lo : (wr_lo | wr_hi);

   always_comb begin
      lo_n     = lo;
      hi_n     = hi;
      ovf_main = 1'b0;
      ovf_hi   = 1'b0;
      if (inc_main && !blk_main) begin
         unique case (mode)
            MD_13: begin
               hi_n              = nxt_short[W_SHORT-1:PRE_W];
               lo_n[PRE_W-1:0]   = nxt_short[PRE_W-1:0];
               ovf_main          = &cur_short;
            end
            MD_16: begin
               {hi_n, lo_n} = nxt_full;
               ovf_main     = &{hi, lo};
            end
            MD_RELOAD: begin
               if (&lo) begin
                  lo_n     = hi;
                  ovf_main = 1'b1;
               end else begin
                  lo_n = lo + 1'b1;
               end
            end
            MD_SPLIT: begin
               if (split) begin
                  lo_n     = lo + 1'b1;
                  ovf_main = &lo;
               end
            end
            default: ;
         endcase
      end
      if (split && inc_hi && !wr_hi) begin
         hi_n   = hi + 1'b1;
         ovf_hi = &hi;
      end
      if (wr_lo) lo_n = wdata;
      if (wr_hi) hi_n = wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo <= '0;
         hi <= '0;
      end else begin
         lo <= lo_n;
         hi <= hi_n;
      end
   end

   // R2: no event and no write leaves both bytes untouched
   p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_main && !inc_hi && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));

   // R4: the unused low-byte bits never move in the short mode
   p_top_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_13 && !wr_lo) |=> (lo[BYTE_W-1:PRE_W] == $past(lo[BYTE_W-1:PRE_W])));

   // R5: reload copies high into low and keeps high
   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_RELOAD && inc_main && !wr_lo && !wr_hi && (&lo)) |=> ((lo == $past(hi)) && $stable(hi)));

   // R11: a bus write always lands, regardless of counting
   p_wr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (lo == $past(wdata)));
endmodule

// File: rtl/dual_tmr_ctr.sv
module dual_tmr_ctr
   import tmr_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int PRE_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [1:0]        cnt_pin,
   input  logic [1:0]        gate_pin,
   input  logic [2:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic [1:0]        ovf_flag
);
   localparam int NUM_CH = 2;

   initial begin
      assert (BYTE_W >= 2 * CFG_BITS) else $fatal(1, "dual_tmr_ctr: BYTE_W too narrow for the configuration register");
   end

   logic [2*CFG_BITS-1:0] cfg_q;
   logic [NUM_CH-1:0]     run_q, flag_q, flag_n;
   chan_cfg_t             cfg [NUM_CH];

   logic [BYTE_W-1:0] lo_q [NUM_CH];
   logic [BYTE_W-1:0] hi_q [NUM_CH];
   logic [NUM_CH-1:0] fall, qual, event_sel, inc_main, inc_hi, wr_lo, wr_hi, ovf_main, ovf_hi;
   logic              split0, wr_cfg, wr_ctrl, flag1_src;

   assign wr_cfg  = bus_wr && (bus_addr == A_CFG);
   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign split0  = (cfg[0].mode == MD_SPLIT);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
         assign cfg[gi]       = chan_cfg_t'(cfg_q[gi*CFG_BITS +: CFG_BITS]);
         assign qual[gi]      = run_q[gi] & (~cfg[gi].gate_en | gate_pin[gi]);
         assign event_sel[gi] = cfg[gi].src_pin ? fall[gi] : tick;
         assign wr_lo[gi]     = bus_wr && (bus_addr == A_LO0 + 3'(2 * gi));
         assign wr_hi[gi]     = bus_wr && (bus_addr == A_HI0 + 3'(2 * gi));

         tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (cnt_pin[gi]),
            .fall (fall[gi])
         );

         tmr_chan #(.BYTE_W(BYTE_W), .PRE_W(PRE_W), .SPLIT_OK(gi == 0)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (cfg[gi].mode),
            .inc_main(inc_main[gi]),
            .inc_hi  (inc_hi[gi]),
            .wr_lo   (wr_lo[gi]),
            .wr_hi   (wr_hi[gi]),
            .wdata   (bus_wdata),
            .lo      (lo_q[gi]),
            .hi      (hi_q[gi]),
            .ovf_main(ovf_main[gi]),
            .ovf_hi  (ovf_hi[gi])
         );
      end
   endgenerate

   // channel 1 freezes in its own split mode; channel 0's high byte borrows run 1
   assign inc_main[0] = qual[0] & event_sel[0];
   assign inc_main[1] = qual[1] & event_sel[1] & (cfg[1].mode != MD_SPLIT);
   assign inc_hi[0]   = run_q[1] & tick;
   assign inc_hi[1]   = 1'b0;

   assign flag1_src = split0 ? (|ovf_hi) : ovf_main[1];

   always_comb begin
      flag_n[0] = wr_ctrl ? bus_wdata[1] : flag_q[0];
      flag_n[1] = wr_ctrl ? bus_wdata[3] : flag_q[1];
      if (ovf_main[0]) flag_n[0] = 1'b1;
      if (flag1_src)   flag_n[1] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         run_q  <= '0;
         flag_q <= '0;
      end else begin
         if (wr_cfg)  cfg_q <= bus_wdata[2*CFG_BITS-1:0];
         if (wr_ctrl) run_q <= {bus_wdata[2], bus_wdata[0]};
         flag_q <= flag_n;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CFG:   bus_rdata[2*CFG_BITS-1:0] = cfg_q;
         A_CTRL:  bus_rdata[3:0] = {flag_q[1], run_q[1], flag_q[0], run_q[0]};
         A_LO0:   bus_rdata = lo_q[0];
         A_HI0:   bus_rdata = hi_q[0];
         A_LO1:   bus_rdata = lo_q[1];
         A_HI1:   bus_rdata = hi_q[1];
         default: bus_rdata = '0;
      endcase
   end

   assign ovf_flag = flag_q;

   // R9: a counted overflow is visible on the flag output next cycle
   p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_main[0] |=> ovf_flag[0]);

   // R6: channel 1 in its split mode never moves except by bus writes
   p_ch1_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[1].mode == MD_SPLIT && !wr_lo[1] && !wr_hi[1]) |=> ($stable(lo_q[1]) && $stable(hi_q[1])));

   // R10: with channel 0 split, channel 1's own wrap does not raise flag 1
   p_no_borrowed_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (split0 && !ovf_hi[0] && !flag_q[1] && !wr_ctrl) |=> !ovf_flag[1]);
endmodule

// File: tb/tb_dual_tmr_ctr.sv
`timescale 1ns/1ps
module tb_dual_tmr_ctr;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] cnt_pin = 2'b00;
   logic [1:0] gate_pin = 2'b00;
   logic [2:0] bus_addr = 3'd0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [1:0] ovf_flag;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dual_tmr_ctr dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .ovf_flag(ovf_flag)
   );

   // {cfg, lo, hi, ticks, exp_lo, exp_hi, exp_flag0}
   localparam logic [55:0] VEC [7] = '{
      56'h01_FE_FF_03_01_00_01,   // R3 16-bit wrap
      56'h01_FF_12_01_00_13_00,   // R3 carry, no flag
      56'h00_FF_FF_01_E0_00_01,   // R4 13-bit wrap, top bits kept
      56'h00_3F_05_02_21_06_00,   // R4 carry out of low 5 bits
      56'h02_FE_80_03_81_80_01,   // R5 reload
      56'h02_10_C0_05_15_C0_00,   // R5 no reload
      56'h03_FF_00_01_00_00_01    // R7 split low byte with run 1 off
   };

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog got=hang exp=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v); check("R1 reg", v, 8'h00);
      end
      check("R1 flags", {6'd0, ovf_flag}, 8'h00);

      // main function table, R12 addressing
      for (int i = 0; i < 7; i++) begin
         wr(3'd0, VEC[i][55:48]);
         wr(3'd3, VEC[i][39:32]);
         wr(3'd2, VEC[i][47:40]);
         wr(3'd1, 8'h01);
         ticks(int'(VEC[i][31:24]));
         rd(3'd2, v); check("R3/R4/R5/R7 vec lo", v, VEC[i][23:16]);
         rd(3'd3, v); check("R3/R4/R5/R7 vec hi", v, VEC[i][15:8]);
         rd(3'd1, v); check("R3/R4/R5/R7 vec flag0", {7'd0, v[1]}, VEC[i][7:0]);
      end

      // R2 gate, run, resume
      wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
      gate_pin[0] = 1'b0; ticks(4);
      rd(3'd2, v); check("R2 gate low holds", v, 8'h00);
      gate_pin[0] = 1'b1; ticks(4);
      rd(3'd2, v); check("R2 gate high counts", v, 8'h04);
      wr(3'd1, 8'h00); ticks(3);
      rd(3'd2, v); check("R2 stopped holds", v, 8'h04);
      wr(3'd1, 8'h01);
      rd(3'd2, v); check("R2 run keeps count", v, 8'h04);
      ticks(1);
      rd(3'd2, v); check("R2 resumes", v, 8'h05);
      gate_pin[0] = 1'b0;

      // R8 counter source
      wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
      ticks(5);
      rd(3'd2, v); check("R8 tick ignored", v, 8'h00);
      for (int k = 0; k < 3; k++) begin
         cnt_pin[0] = 1'b1; repeat (4) @(negedge clk);
         cnt_pin[0] = 1'b0; repeat (4) @(negedge clk);
      end
      rd(3'd2, v); check("R8 falling edges", v, 8'h03);

      // R7 split high byte on run 1 and flag 1
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h03); wr(3'd2, 8'h00); wr(3'd3, 8'hFE); wr(3'd1, 8'h04);
      ticks(2);
      rd(3'd3, v); check("R7 hi wraps", v, 8'h00);
      rd(3'd2, v); check("R7 lo stays with run0 off", v, 8'h00);
      rd(3'd1, v); check("R7 ctrl flag1", v, 8'h0C);
      check("R7 flag pin", {6'd0, ovf_flag}, 8'h02);

      // R10 channel 1 counts but cannot set flag 1
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h13); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd3, 8'h10); wr(3'd1, 8'h04);
      ticks(1);
      rd(3'd4, v); check("R10 ch1 lo", v, 8'h00);
      rd(3'd5, v); check("R10 ch1 hi", v, 8'h00);
      rd(3'd3, v); check("R10 ch0 hi", v, 8'h11);
      rd(3'd1, v); check("R10 no flag1", v, 8'h04);

      // R6 channel 1 frozen in mode 3
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h30); wr(3'd4, 8'h05); wr(3'd5, 8'h00); wr(3'd1, 8'h04);
      ticks(3);
      rd(3'd4, v); check("R6 ch1 frozen", v, 8'h05);
      rd(3'd1, v); check("R6 no flag", v, 8'h04);

      // R9 hardware set beats clear, then plain clear
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd1, 8'h03);
      tick = 1'b1; wr(3'd1, 8'h01); tick = 1'b0;
      rd(3'd1, v); check("R9 set wins", v, 8'h03);
      rd(3'd2, v); check("R9 wrapped", v, 8'h00);
      wr(3'd1, 8'h01);
      rd(3'd1, v); check("R9 cleared", v, 8'h01);

      // R11 write beats increment
      wr(3'd2, 8'h10);
      tick = 1'b1; wr(3'd2, 8'h50); tick = 1'b0;
      rd(3'd2, v); check("R11 write kept", v, 8'h50);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule